// File: doc/BRIEF.md
# Push/pop macro instruction sequencer

This block sits in the decode stage between the compressed-instruction expander and the main decoder. When a 16-bit stack-management or register-pair-move macro is flagged, the sequencer turns it into an ordered series of ordinary 32-bit RV32 instructions. It presents one word at a time and moves to the next word only when the issue stage acknowledges the current one. While a series is in progress it holds instruction fetch stalled. It also latches the macro, so the fetch side may change its input freely after the first word is accepted.

The final word of every series carries a last marker. Commit logic can therefore retire the whole macro as a single instruction: it counts a commit when the word is either unexpanded or marked last. An unflagged instruction flows through unchanged in the same cycle. A flagged macro whose encoding is not allowed raises an illegal flag instead of starting a series.

Top module: `zseq_top`

## Requirements
- R1: With `is_macro_i` high, the low half `h` of `instr_i` is decoded as follows, where `h[1:0]=10`, `h[15:13]=101`, rlist is `h[7:4]` and spimm is `h[3:2]`. `h[12:8]=11000` is push, `11010` is pop, `11110` is pop-and-return and `11100` is pop-and-return-zero. `h[12:10]=011` with `h[6:5]=01` moves a0/a1 into saved registers, and with `h[6:5]=11` moves saved registers into a0/a1; in both moves the saved fields are `h[9:7]` and `h[4:2]`. A legal macro raises `busy_o` in the cycle it is presented.
- R2: `busy_o` stays high from the first generated word until the cycle that the final word is acknowledged. This holds through cycles without acknowledge and while `instr_i` and `is_macro_i` change after the first acknowledge.
- R3: The presented word and `last_o` change only after a cycle with `issue_ack_i` high. Exactly one word is consumed per acknowledged cycle.
- R4: Push first emits `sw reg_k, -4(k+1)(x2)` for each listed register k = 0..n-1. The list order is ra, s0, s1, … (x1, x8, x9, x18…x27). rlist values 4..14 list ra plus rlist-4 saved registers; 15 lists ra plus s0..s11. After the stores it emits `addi x2,x2,-adj`.
- R5: adj equals 4n rounded up to a multiple of 16, plus 16·spimm.
- R6: Every stack-pointer adjustment is an OP-IMM add-immediate (opcode 0010011). It has rd=x2, rs1=x2, funct3=000 and the signed 12-bit amount in bits [31:20].
- R7: Pop emits `lw reg_k, adj-4(k+1)(x2)` for k = 0..n-1, in list order, and then `addi x2,x2,adj`.
- R8: After the pop words, pop-and-return-zero emits `addi x10,x0,0` and then `jalr x0,0(x1)`. Pop-and-return emits only `jalr x0,0(x1)`.
- R9: Saved field code s maps to x8+s for s<2 and to x16+s for s≥2. Move-to-saved emits `addi S1,x10,0` then `addi S2,x11,0`. Move-to-a0/a1 emits `addi x10,S1,0` then `addi x11,S2,0`.
- R10: `last_o` is high only while the final generated word is presented. After that word is acknowledged the block is idle, with `busy_o` low.
- R11: A flagged word is illegal if it matches no macro, if it is push/pop with rlist below 4, or if it is a move-to-saved with equal fields. For an illegal word, `illegal_o` is high, `valid_o` is low, `busy_o` and `last_o` are low and `instr_o` is zero.
- R12: When idle and unflagged, `instr_o` equals `instr_i` in the same cycle, with `valid_o` high and `busy_o`, `last_o` and `illegal_o` low.
- R13: After reset the block is idle: `busy_o` and `last_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Incoming instruction; a macro sits in bits [15:0] |
| is_macro_i | input | 1 | Marks `instr_i` as a macro to expand |
| issue_ack_i | input | 1 | Issue stage accepted the presented word |
| instr_o | output | 32 | Generated or passed-through instruction |
| valid_o | output | 1 | `instr_o` holds a usable instruction |
| busy_o | output | 1 | Expansion in progress; stall fetch |
| last_o | output | 1 | Presented word is the final one of its macro |
| illegal_o | output | 1 | Flagged word is not a legal macro |

## Verification
The bench builds the block with its default 16-byte stack alignment. At that setting, every rlist value from 4 to 15 combined with all four spimm values yields an adjustment that fits the 12-bit immediate. This makes the 13-register, 112-byte worst case reachable along with every series length from 2 to 16 words. Series are run both back-to-back and with acknowledge gaps, and the fetch input is scrambled mid-series. This shows that the latched macro, not the live input, drives the remaining words.

// File: rtl/zseq_pkg.sv
package zseq_pkg;

  localparam int MAX_LIST  = 13;
  localparam int MAX_STEPS = MAX_LIST + 3;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [4:0] X_RA = 5'd1;
  localparam logic [4:0] X_SP = 5'd2;
  localparam logic [4:0] X_A0 = 5'd10;
  localparam logic [4:0] X_A1 = 5'd11;

  typedef enum logic [2:0] {
    OP_NONE, OP_PUSH, OP_POP, OP_POPRET, OP_POPRETZ, OP_TO_SAVED, OP_TO_ARGS
  } mop_e;

  function automatic logic [4:0] list_len(input logic [3:0] rl);
    return (rl == 4'd15) ? 5'd13 : 5'(rl) - 5'd3;
  endfunction

  function automatic logic [11:0] frame_bytes(input logic [3:0] rl,
                                               input logic [1:0] sp,
                                               input int unsigned align);
    logic [11:0] raw;
    logic [11:0] mask;
    raw  = 12'(list_len(rl)) << 2;
    mask = 12'(align - 1);
    return ((raw + mask) & ~mask) + 12'(sp) * 12'(align);
  endfunction

  function automatic logic [4:0] list_reg(input logic [3:0] idx);
    case (idx)
      4'd0:    return X_RA;
      4'd1:    return 5'd8;
      4'd2:    return 5'd9;
      default: return 5'(idx) + 5'd15;
    endcase
  endfunction

  function automatic logic [4:0] sreg(input logic [2:0] code);
    return (code < 3'd2) ? (5'd8 + 5'(code)) : (5'd16 + 5'(code));
  endfunction

  function automatic logic [31:0] enc_addi(input logic [4:0] rd, input logic [4:0] rs,
                                           input logic [11:0] imm);
    return {imm, rs, 3'b000, rd, OPC_OPIMM};
  endfunction

  function automatic logic [31:0] enc_sw(input logic [4:0] src, input logic [11:0] off);
    return {off[11:5], src, X_SP, 3'b010, off[4:0], OPC_STORE};
  endfunction

  function automatic logic [31:0] enc_lw(input logic [4:0] dst, input logic [11:0] off);
    return {off, X_SP, 3'b010, dst, OPC_LOAD};
  endfunction

  function automatic logic [31:0] enc_ret();
    return {12'd0, X_RA, 3'b000, 5'd0, OPC_JALR};
  endfunction

endpackage

// File: rtl/zseq_fields.sv
module zseq_fields
  import zseq_pkg::*;
#(
  parameter int unsigned ALIGN = 16
) (
  input  logic [15:0]       half_i,
  output mop_e              op_o,
  output logic [3:0]        rlist_o,
  output logic [2:0]        s1_o,
  output logic [2:0]        s2_o,
  output logic [11:0]       adj_o,
  output logic [STEP_W-1:0] nsteps_o,
  output logic              bad_o
);

  logic [4:0] n;

  always_comb begin
    op_o    = OP_NONE;
    rlist_o = half_i[7:4];
    s1_o    = half_i[9:7];
    s2_o    = half_i[4:2];
    if (half_i[1:0] == 2'b10 && half_i[15:13] == 3'b101) begin
      case (half_i[12:8])
        5'b11000: op_o = OP_PUSH;
        5'b11010: op_o = OP_POP;
        5'b11110: op_o = OP_POPRET;
        5'b11100: op_o = OP_POPRETZ;
        default: begin
          if (half_i[12:10] == 3'b011 && half_i[6:5] == 2'b01) op_o = OP_TO_SAVED;
          else if (half_i[12:10] == 3'b011 && half_i[6:5] == 2'b11) op_o = OP_TO_ARGS;
        end
      endcase
    end
  end

  assign n     = list_len(rlist_o);
  assign adj_o = frame_bytes(rlist_o, half_i[3:2], ALIGN);

  always_comb begin
    bad_o    = 1'b0;
    nsteps_o = STEP_W'(1);
    case (op_o)
      OP_PUSH, OP_POP: begin
        bad_o    = (rlist_o < 4'd4);
        nsteps_o = STEP_W'(n) + STEP_W'(1);
      end
      OP_POPRET: begin
        bad_o    = (rlist_o < 4'd4);
        nsteps_o = STEP_W'(n) + STEP_W'(2);
      end
      OP_POPRETZ: begin
        bad_o    = (rlist_o < 4'd4);
        nsteps_o = STEP_W'(n) + STEP_W'(3);
      end
      OP_TO_SAVED: begin
        bad_o    = (s1_o == s2_o);
        nsteps_o = STEP_W'(2);
      end
      OP_TO_ARGS: nsteps_o = STEP_W'(2);
      default:    bad_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/zseq_word.sv
module zseq_word
  import zseq_pkg::*;
(
  input  mop_e              op_i,
  input  logic [3:0]        rlist_i,
  input  logic [2:0]        s1_i,
  input  logic [2:0]        s2_i,
  input  logic [11:0]       adj_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [31:0]       word_o
);

  logic [4:0]  n;
  logic [4:0]  step5;
  logic [11:0] slot_off;
  logic [4:0]  reg_k;
  logic        in_list;

  assign n        = list_len(rlist_i);
  assign step5    = 5'(step_i);
  assign slot_off = (12'(step_i) + 12'd1) << 2;
  assign reg_k    = list_reg(step_i[3:0]);
  assign in_list  = (step5 < n);

  always_comb begin
    word_o = 32'd0;
    case (op_i)
      OP_PUSH: begin
        if (in_list) word_o = enc_sw(reg_k, 12'd0 - slot_off);
        else         word_o = enc_addi(X_SP, X_SP, 12'd0 - adj_i);
      end
      OP_POP, OP_POPRET, OP_POPRETZ: begin
        if (in_list)                                    word_o = enc_lw(reg_k, adj_i - slot_off);
        else if (step5 == n)                            word_o = enc_addi(X_SP, X_SP, adj_i);
        else if (op_i == OP_POPRETZ && step5 == n + 5'd1) word_o = enc_addi(X_A0, 5'd0, 12'd0);
        else                                            word_o = enc_ret();
      end
      OP_TO_SAVED: begin
        if (step_i == '0) word_o = enc_addi(sreg(s1_i), X_A0, 12'd0);
        else              word_o = enc_addi(sreg(s2_i), X_A1, 12'd0);
      end
      OP_TO_ARGS: begin
        if (step_i == '0) word_o = enc_addi(X_A0, sreg(s1_i), 12'd0);
        else              word_o = enc_addi(X_A1, sreg(s2_i), 12'd0);
      end
      default: word_o = 32'd0;
    endcase
  end

endmodule

// File: rtl/zseq_ctrl.sv
module zseq_ctrl
  import zseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       half_live_i,
  input  logic              is_macro_i,
  input  logic              issue_ack_i,
  input  logic              bad_i,
  input  logic [STEP_W-1:0] nsteps_i,
  output logic [15:0]       half_o,
  output logic [STEP_W-1:0] step_o,
  output logic              busy_q_o,
  output logic              expanding_o,
  output logic              last_o,
  output logic              advance_o
);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [15:0]       hold_q;

  assign half_o      = busy_q ? hold_q : half_live_i;
  assign step_o      = busy_q ? step_q : '0;
  assign expanding_o = busy_q | (is_macro_i & ~bad_i);
  assign last_o      = expanding_o & (step_o == STEP_W'(nsteps_i - STEP_W'(1)));
  assign advance_o   = expanding_o & issue_ack_i;
  assign busy_q_o    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      hold_q <= '0;
    end else if (advance_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        busy_q <= 1'b1;
        step_q <= step_o + STEP_W'(1);
        hold_q <= half_o;
      end
    end
  end

endmodule

// File: rtl/zseq_top.sv
module zseq_top
  import zseq_pkg::*;
#(
  parameter int unsigned STACK_ALIGN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr_i,
  input  logic        is_macro_i,
  input  logic        issue_ack_i,
  output logic [31:0] instr_o,
  output logic        valid_o,
  output logic        busy_o,
  output logic        last_o,
  output logic        illegal_o
);

  logic [15:0]       cur_half;
  logic [STEP_W-1:0] cur_step;
  logic              busy_q;
  logic              expanding;
  logic              advance;
  logic              bad;
  logic [STEP_W-1:0] nsteps;
  mop_e              op;
  logic [3:0]        rlist;
  logic [2:0]        s1;
  logic [2:0]        s2;
  logic [11:0]       adj;
  logic [31:0]       gen_word;

  zseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_live_i (instr_i[15:0]),
    .is_macro_i  (is_macro_i),
    .issue_ack_i (issue_ack_i),
    .bad_i       (bad),
    .nsteps_i    (nsteps),
    .half_o      (cur_half),
    .step_o      (cur_step),
    .busy_q_o    (busy_q),
    .expanding_o (expanding),
    .last_o      (last_o),
    .advance_o   (advance)
  );

  zseq_fields #(.ALIGN(STACK_ALIGN)) u_fields (
    .half_i   (cur_half),
    .op_o     (op),
    .rlist_o  (rlist),
    .s1_o     (s1),
    .s2_o     (s2),
    .adj_o    (adj),
    .nsteps_o (nsteps),
    .bad_o    (bad)
  );

  zseq_word u_word (
    .op_i    (op),
    .rlist_i (rlist),
    .s1_i    (s1),
    .s2_i    (s2),
    .adj_i   (adj),
    .step_i  (cur_step),
    .word_o  (gen_word)
  );

  assign illegal_o = is_macro_i & ~busy_q & bad;
  assign busy_o    = expanding;
  assign valid_o   = ~illegal_o;
  assign instr_o   = expanding ? gen_word : (illegal_o ? 32'd0 : instr_i);

endmodule

// File: rtl/zseq_checks.sv
module zseq_checks
  import zseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       instr_i,
  input logic              issue_ack_i,
  input logic [31:0]       instr_o,
  input logic              valid_o,
  input logic              busy_o,
  input logic              last_o,
  input logic              illegal_o,
  input logic              busy_q,
  input logic [STEP_W-1:0] cur_step
);

  a_r2_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> busy_o);

  a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !issue_ack_i |=> $stable(instr_o) && $stable(last_o));

  a_r3_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && issue_ack_i && !last_o |=> busy_q && cur_step == STEP_W'($past(cur_step) + STEP_W'(1)));

  a_r3_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !issue_ack_i |=> busy_q && $stable(cur_step));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && issue_ack_i |=> !busy_q);

  a_r10_last_in_series: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> busy_o);

  a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !busy_o && !valid_o && !last_o && instr_o == 32'd0);

  a_r12_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !illegal_o |-> instr_o == instr_i && valid_o);

endmodule

bind zseq_top zseq_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_i     (instr_i),
  .issue_ack_i (issue_ack_i),
  .instr_o     (instr_o),
  .valid_o     (valid_o),
  .busy_o      (busy_o),
  .last_o      (last_o),
  .illegal_o   (illegal_o),
  .busy_q      (busy_q),
  .cur_step    (cur_step)
);

// File: tb/sim_zseq_top.sv
`timescale 1ns/100ps
module sim_zseq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = 32'd0;
  logic        is_macro_i = 1'b0;
  logic        issue_ack_i = 1'b0;
  logic [31:0] instr_o;
  logic        valid_o, busy_o, last_o, illegal_o;

  always #2.5 clk = ~clk;

  zseq_top u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .is_macro_i(is_macro_i),
    .issue_ack_i(issue_ack_i), .instr_o(instr_o), .valid_o(valid_o),
    .busy_o(busy_o), .last_o(last_o), .illegal_o(illegal_o)
  );

  typedef struct {
    logic [31:0] w;
    logic        last;
    logic        busy;
    logic        ill;
    string       req;
  } exp_t;

  exp_t sbq[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  int   saved_map[13] = '{1, 8, 9, 18, 19, 20, 21, 22, 23, 24, 25, 26, 27};

  function automatic logic [31:0] m_addi(int rd, int rs, int imm);
    return ((32'(imm) & 32'hFFF) << 20) | (32'(rs) << 15) | (32'(rd) << 7) | 32'h13;
  endfunction
  function automatic logic [31:0] m_sw(int src, int off);
    logic [31:0] o;
    o = 32'(off) & 32'hFFF;
    return ((o >> 5) << 25) | (32'(src) << 20) | (32'd2 << 15) | (32'd2 << 12)
           | ((o & 32'h1F) << 7) | 32'h23;
  endfunction
  function automatic logic [31:0] m_lw(int dst, int off);
    return ((32'(off) & 32'hFFF) << 20) | (32'd2 << 15) | (32'd2 << 12) | (32'(dst) << 7) | 32'h03;
  endfunction
  function automatic int s_code_reg(int c);
    int tbl[8] = '{8, 9, 18, 19, 20, 21, 22, 23};
    return tbl[c];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [31:0] w, input logic last, input logic busy,
                          input logic ill, input string req);
    exp_t e;
    e.w = w; e.last = last; e.busy = busy; e.ill = ill; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: samples at the falling edge, inputs change just after the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        if (issue_ack_i) begin
          if (sbq.size() == 0) begin
            check(1'b0, "R3", "unexpected acknowledged word", instr_o, 32'd0);
          end else begin
            exp_t e;
            e = sbq.pop_front();
            check(instr_o == e.w, e.req, "word", instr_o, e.w);
            check(last_o == e.last, "R10", {e.req, " last"}, 32'(last_o), 32'(e.last));
            check(busy_o == e.busy, "R1/R2", {e.req, " busy"}, 32'(busy_o), 32'(e.busy));
            check(illegal_o == e.ill, "R11", {e.req, " illegal"}, 32'(illegal_o), 32'(e.ill));
            check(valid_o == !e.ill, "R11/R12", {e.req, " valid"}, 32'(valid_o), 32'(!e.ill));
          end
        end else if (busy_o && sbq.size() > 0) begin
          check(instr_o == sbq[0].w, "R3", "word while unacknowledged", instr_o, sbq[0].w);
          check(busy_o, "R2", "stall held", 32'(busy_o), 32'd1);
        end
      end
    end
  end

  task automatic drive_series(input logic [15:0] h, input int count, input int gap);
    instr_i    = {16'h0000, h};
    is_macro_i = 1'b1;
    for (int k = 0; k < count; k++) begin
      repeat (gap) begin
        issue_ack_i = 1'b0;
        @(posedge clk); #1;
      end
      issue_ack_i = 1'b1;
      @(posedge clk); #1;
      if (k == 0) begin
        // scramble the fetch side: the latched macro must drive the rest (R2)
        instr_i    = 32'hDEAD_0F0F ^ 32'(count);
        is_macro_i = 1'b0;
      end
    end
    issue_ack_i = 1'b0;
    is_macro_i  = 1'b0;
  endtask

  // kind: 0 push, 1 pop, 2 pop-return, 3 pop-return-zero
  task automatic run_stack(input int kind, input int rlist, input int spimm, input int gap);
    int sel[4] = '{24, 26, 30, 28};  // R1 function codes
    int n, adj, total, cnt;
    logic [15:0] h;
    h = {3'b101, 5'(sel[kind]), 4'(rlist), 2'(spimm), 2'b10};
    n = (rlist == 15) ? 13 : rlist - 3;
    adj = ((4 * n + 15) / 16) * 16 + 16 * spimm;  // R5
    total = n + 1 + ((kind == 2) ? 1 : 0) + ((kind == 3) ? 2 : 0);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      cnt++;
      if (kind == 0) push_exp(m_sw(saved_map[k], -4 * (k + 1)), cnt == total, 1'b1, 1'b0, "R4");
      else           push_exp(m_lw(saved_map[k], adj - 4 * (k + 1)), cnt == total, 1'b1, 1'b0, "R7");
    end
    cnt++;
    push_exp(m_addi(2, 2, (kind == 0) ? -adj : adj), cnt == total, 1'b1, 1'b0, "R5/R6");
    if (kind == 3) begin
      cnt++;
      push_exp(m_addi(10, 0, 0), 1'b0, 1'b1, 1'b0, "R8");
    end
    if (kind >= 2) begin
      cnt++;
      push_exp(32'h0000_8067, 1'b1, 1'b1, 1'b0, "R8");
    end
    drive_series(h, total, gap);
  endtask

  task automatic run_move(input bit to_saved, input int c1, input int c2, input int gap);
    logic [15:0] h;
    h = {6'b101011, 3'(c1), to_saved ? 2'b01 : 2'b11, 3'(c2), 2'b10};
    if (to_saved) begin
      push_exp(m_addi(s_code_reg(c1), 10, 0), 1'b0, 1'b1, 1'b0, "R9");
      push_exp(m_addi(s_code_reg(c2), 11, 0), 1'b1, 1'b1, 1'b0, "R9");
    end else begin
      push_exp(m_addi(10, s_code_reg(c1), 0), 1'b0, 1'b1, 1'b0, "R9");
      push_exp(m_addi(11, s_code_reg(c2), 0), 1'b1, 1'b1, 1'b0, "R9");
    end
    drive_series(h, 2, gap);
  endtask

  task automatic run_single(input logic [31:0] w, input bit flagged, input bit bad);
    instr_i     = w;
    is_macro_i  = flagged;
    issue_ack_i = 1'b1;
    if (bad) push_exp(32'd0, 1'b0, 1'b0, 1'b1, "R11");
    else     push_exp(w, 1'b0, 1'b0, 1'b0, "R12");
    @(posedge clk); #1;
    issue_ack_i = 1'b0;
    is_macro_i  = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0, "R13", "busy after reset", 32'(busy_o), 32'd0);
    check(last_o == 1'b0, "R13", "last after reset", 32'(last_o), 32'd0);
    @(posedge clk); #1;

    run_single(32'h0040_0093, 1'b0, 1'b0);
    run_stack(0, 4, 0, 0);
    run_single(32'h1234_5678, 1'b0, 1'b0);     // R10: idle again, passes through
    run_stack(0, 15, 3, 1);
    run_stack(0, 7, 1, 2);
    run_stack(1, 5, 0, 0);
    run_stack(2, 6, 2, 1);
    run_stack(3, 15, 0, 0);
    run_stack(3, 4, 1, 3);
    run_move(1'b1, 0, 7, 0);
    run_move(1'b0, 3, 1, 2);
    run_move(1'b1, 2, 1, 1);
    run_single({16'h0, 3'b101, 5'b11000, 4'd3, 2'd0, 2'b10}, 1'b1, 1'b1);  // R11 rlist<4
    run_single({16'h0, 6'b101011, 3'd2, 2'b01, 3'd2, 2'b10}, 1'b1, 1'b1);  // R11 equal fields
    run_single(32'h0000_0001, 1'b1, 1'b1);                                  // R11 no match
    run_single(32'hFFFF_FFFF, 1'b0, 1'b0);
    for (int r = 4; r < 16; r++) begin
      run_stack(0, r, r % 4, r % 2);
      run_stack(1 + (r % 3), r, (r + 1) % 4, 0);
    end
    repeat (3) @(posedge clk);
    check(sbq.size() == 0, "R3", "words left unconsumed", 32'(sbq.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule